// File: doc/BRIEF.md
# Interleaved Memory Conflict Serializer

This block schedules a small group of memory requests onto a memory system whose address space is spread over several channels and several banks by low-order interleaving. A group holds up to `N_REQ` addresses, each with its own enable bit in a lane mask. The block works out the channel and the bank that each address falls on. It then issues the lanes over as few cycles as a greedy in-order pass allows. Two lanes that share a channel, or that share a bank, never go out in the same cycle.

Each issue cycle produces a registered set of outputs: a lane vector marking the lanes granted in that cycle, and the channel code and bank code of every lane. A running cycle count and a last-cycle flag tell the downstream memory controller when the group is finished. New work is taken only once the current group has fully drained. Whatever the input side presents while a group is in flight is ignored.

Top module: `ilv_conflict_serializer`

## Requirements
- R1: Each lane's channel code is (address − 1) mod `N_CHAN`, where code c stands for channel c+1. With the default of 4 channels, addresses 1, 2, 3 and 4 give codes 0, 1, 2 and 3, and address 5 gives code 0 again. `iss_chan` holds lane i in bits [i*CH_W +: CH_W].
- R2: Each lane's bank code is (address − 1) mod `N_BANK`. With the default of 2 banks, codes 0 and 1 alternate on consecutive addresses. `iss_bank` holds lane i in bits [i*BK_W +: BK_W].
- R3: No two lanes granted in the same issue cycle have the same channel code.
- R4: No two lanes granted in the same issue cycle have the same bank code.
- R5: A group is taken on a rising edge where both `in_valid` and `in_ready` are high. `in_ready` then stays low until the final issue cycle of that group. While `in_ready` is low, `in_valid`, `in_mask` and `in_addr` have no effect on the schedule.
- R6: In every issue cycle the lowest-index pending lane is granted. The remaining pending lanes are then considered in rising index order, and each is granted if it clashes on neither channel nor bank with a lane already granted in that cycle. Bit i of `iss_vec` marks lane i.
- R7: Each issue cycle grants at least one lane and at most `N_BANK` lanes. The first issue cycle is registered on the rising edge after the accepting edge, and later issue cycles follow on consecutive edges with no gap.
- R8: `grp_cycles` gives the ordinal of the current issue cycle, starting at 1. `iss_last` is high only on the final issue cycle of a group, so on that cycle `grp_cycles` is the total count. `in_ready` is high in that same cycle.
- R9: Lanes whose mask bit is 0 are never issued. A group whose mask is all zero is taken, produces no issue cycle, and leaves `in_ready` high.
- R10: Under the defaults, the group 1, 6, 11, 16 has channel codes 0, 1, 2, 3 and bank codes 0, 1, 0, 1, and issues as lanes {0,1} then {2,3}. The group 1, 5, 9, 13 issues one lane per cycle in lane order, over 4 cycles.
- R11: After reset, `in_ready` is 1 and `iss_valid`, `iss_last` and `grp_cycles` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new group is presented |
| in_ready | output | 1 | Block can take a group this cycle |
| in_mask | input | N_REQ | Lane enables of the presented group |
| in_addr | input | N_REQ*ADDR_W | Lane addresses, lane i in [i*ADDR_W +: ADDR_W] |
| iss_valid | output | 1 | An issue cycle is on the outputs |
| iss_vec | output | N_REQ | Lanes granted in this issue cycle |
| iss_chan | output | N_REQ*CH_W | Channel code of each lane |
| iss_bank | output | N_REQ*BK_W | Bank code of each lane |
| iss_last | output | 1 | Final issue cycle of the group |
| grp_cycles | output | CNT_W | Ordinal of this issue cycle within the group |

## Verification
The directed groups cover several cases. A stride of 5 from address 1 is free on channels but limited by banks. A stride of 4 collides on both resources and is fully serialized. A run of consecutive addresses separates a bank limit from a channel limit. Duplicate addresses, a single lane, a fully masked group and a group with lane 0 disabled each show whether the head-of-line rule follows the lowest pending lane rather than lane 0. Random groups use addresses drawn from a narrow range, so collisions are frequent. They are mixed with random masks, and many of them hold junk on the input side while busy, which tells a design that ignores in-flight input from one that latches it. Each issue vector, each lane's channel and bank codes, the cycle ordinal and the handshake timing are compared with a greedy schedule computed in the bench.

// File: rtl/ilv_ser_pkg.sv
package ilv_ser_pkg;

  typedef enum logic [0:0] {
    SER_IDLE = 1'b0,
    SER_BUSY = 1'b1
  } ser_state_e;

  function automatic int unsigned code_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/ilv_lane_map.sv
module ilv_lane_map #(
  parameter int ADDR_W = 16,
  parameter int N_CHAN = 4,
  parameter int N_BANK = 2,
  parameter int CH_W   = 2,
  parameter int BK_W   = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [CH_W-1:0]   chan,
  output logic [BK_W-1:0]   bank
);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] ch_full;
  logic [ADDR_W-1:0] bk_full;

  // positions are numbered from 1, so shift to a zero base before folding
  assign off     = addr - ADDR_W'(1);
  assign ch_full = off % ADDR_W'(N_CHAN);
  assign bk_full = off % ADDR_W'(N_BANK);
  assign chan    = CH_W'(ch_full);
  assign bank    = BK_W'(bk_full);

endmodule

// File: rtl/ilv_grant_pick.sv
module ilv_grant_pick #(
  parameter int N_REQ = 4,
  parameter int CH_W  = 2,
  parameter int BK_W  = 1
) (
  input  logic [N_REQ-1:0]           pend,
  input  logic [N_REQ-1:0][CH_W-1:0] lane_ch,
  input  logic [N_REQ-1:0][BK_W-1:0] lane_bk,
  output logic [N_REQ-1:0]           grant
);

  // greedy pass in lane order: a lane joins the cycle only if it clashes
  // with none of the lower lanes already chosen
  always_comb begin
    grant = '0;
    for (int i = 0; i < N_REQ; i++) begin
      logic free;
      free = pend[i];
      for (int j = 0; j < N_REQ; j++) begin
        if (j < i && grant[j] &&
            (lane_ch[j] == lane_ch[i] || lane_bk[j] == lane_bk[i]))
          free = 1'b0;
      end
      grant[i] = free;
    end
  end

endmodule

// File: rtl/ilv_ser_ctrl.sv
module ilv_ser_ctrl
  import ilv_ser_pkg::*;
#(
  parameter int N_REQ  = 4,
  parameter int N_BANK = 2,
  parameter int CH_W   = 2,
  parameter int BK_W   = 1,
  parameter int CNT_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [N_REQ-1:0]           in_mask,
  input  logic [N_REQ-1:0][CH_W-1:0] map_ch,
  input  logic [N_REQ-1:0][BK_W-1:0] map_bk,
  output logic                       in_ready,
  output logic [N_REQ-1:0]           iss_valid_vec,
  output logic                       iss_valid,
  output logic [N_REQ-1:0][CH_W-1:0] iss_ch,
  output logic [N_REQ-1:0][BK_W-1:0] iss_bk,
  output logic                       iss_last,
  output logic [CNT_W-1:0]           grp_cycles
);

  ser_state_e                 state;
  logic [N_REQ-1:0]           pend;
  logic [N_REQ-1:0][CH_W-1:0] lane_ch;
  logic [N_REQ-1:0][BK_W-1:0] lane_bk;
  logic [N_REQ-1:0]           grant;
  logic [N_REQ-1:0]           rest;
  logic [CNT_W-1:0]           cnt;
  logic [CNT_W-1:0]           cnt_nx;

  ilv_grant_pick #(
    .N_REQ (N_REQ),
    .CH_W  (CH_W),
    .BK_W  (BK_W)
  ) i_pick (
    .pend    (pend),
    .lane_ch (lane_ch),
    .lane_bk (lane_bk),
    .grant   (grant)
  );

  assign rest     = pend & ~grant;
  assign cnt_nx   = cnt + CNT_W'(1);
  assign in_ready = (state == SER_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= SER_IDLE;
      pend          <= '0;
      lane_ch       <= '0;
      lane_bk       <= '0;
      cnt           <= '0;
      iss_valid     <= 1'b0;
      iss_valid_vec <= '0;
      iss_ch        <= '0;
      iss_bk        <= '0;
      iss_last      <= 1'b0;
      grp_cycles    <= '0;
    end else begin
      case (state)
        SER_IDLE: begin
          iss_valid     <= 1'b0;
          iss_last      <= 1'b0;
          iss_valid_vec <= '0;
          if (in_valid) begin
            // keep only the folded codes: the addresses are not needed again
            lane_ch <= map_ch;
            lane_bk <= map_bk;
            pend    <= in_mask;
            cnt     <= '0;
            if (in_mask != '0) state <= SER_BUSY;
          end
        end
        SER_BUSY: begin
          iss_valid     <= 1'b1;
          iss_valid_vec <= grant;
          iss_ch        <= lane_ch;
          iss_bk        <= lane_bk;
          cnt           <= cnt_nx;
          grp_cycles    <= cnt_nx;
          pend          <= rest;
          if (rest == '0) begin
            iss_last <= 1'b1;
            state    <= SER_IDLE;
          end else begin
            iss_last <= 1'b0;
          end
        end
        default: state <= SER_IDLE;
      endcase
    end
  end

  logic [N_REQ-1:0] head;
  assign head = pend & (~pend + N_REQ'(1));

  AST_HEAD_FIRST: assert property (@(posedge clk) disable iff (rst)
    (state == SER_BUSY) |-> ((grant & head) != '0)); // R6

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (state == SER_BUSY) |=> ($stable(lane_ch) && $stable(lane_bk))); // R5

  AST_GRANT_CAP: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> (iss_valid_vec != '0 && $countones(iss_valid_vec) <= N_BANK)); // R7

  AST_LAST_READY: assert property (@(posedge clk) disable iff (rst)
    iss_last |-> (in_ready && iss_valid && grp_cycles != '0)); // R8

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_last) |-> !in_ready); // R5

endmodule

// File: rtl/ilv_conflict_serializer.sv
module ilv_conflict_serializer
  import ilv_ser_pkg::*;
#(
  parameter int N_REQ  = 4,
  parameter int ADDR_W = 16,
  parameter int N_CHAN = 4,
  parameter int N_BANK = 2,
  localparam int CH_W  = code_width(N_CHAN),
  localparam int BK_W  = code_width(N_BANK),
  localparam int CNT_W = $clog2(N_REQ + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [N_REQ-1:0]        in_mask,
  input  logic [N_REQ*ADDR_W-1:0] in_addr,
  output logic                    iss_valid,
  output logic [N_REQ-1:0]        iss_vec,
  output logic [N_REQ*CH_W-1:0]   iss_chan,
  output logic [N_REQ*BK_W-1:0]   iss_bank,
  output logic                    iss_last,
  output logic [CNT_W-1:0]        grp_cycles
);

  logic [N_REQ-1:0][CH_W-1:0] map_ch;
  logic [N_REQ-1:0][BK_W-1:0] map_bk;
  logic [N_REQ-1:0][CH_W-1:0] out_ch;
  logic [N_REQ-1:0][BK_W-1:0] out_bk;

  for (genvar g = 0; g < N_REQ; g++) begin : g_lane
    ilv_lane_map #(
      .ADDR_W (ADDR_W),
      .N_CHAN (N_CHAN),
      .N_BANK (N_BANK),
      .CH_W   (CH_W),
      .BK_W   (BK_W)
    ) i_map (
      .addr (in_addr[g*ADDR_W +: ADDR_W]),
      .chan (map_ch[g]),
      .bank (map_bk[g])
    );
  end

  ilv_ser_ctrl #(
    .N_REQ  (N_REQ),
    .N_BANK (N_BANK),
    .CH_W   (CH_W),
    .BK_W   (BK_W),
    .CNT_W  (CNT_W)
  ) i_ctrl (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_mask       (in_mask),
    .map_ch        (map_ch),
    .map_bk        (map_bk),
    .in_ready      (in_ready),
    .iss_valid_vec (iss_vec),
    .iss_valid     (iss_valid),
    .iss_ch        (out_ch),
    .iss_bk        (out_bk),
    .iss_last      (iss_last),
    .grp_cycles    (grp_cycles)
  );

  assign iss_chan = out_ch;
  assign iss_bank = out_bk;

  // clash detection on the registered outputs, for the checks below
  logic ch_clash;
  logic bk_clash;
  always_comb begin
    ch_clash = 1'b0;
    bk_clash = 1'b0;
    for (int i = 0; i < N_REQ; i++) begin
      for (int j = 0; j < N_REQ; j++) begin
        if (j > i && iss_vec[i] && iss_vec[j]) begin
          if (out_ch[i] == out_ch[j]) ch_clash = 1'b1;
          if (out_bk[i] == out_bk[j]) bk_clash = 1'b1;
        end
      end
    end
  end

  AST_NO_CHAN_CLASH: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> !ch_clash); // R3

  AST_NO_BANK_CLASH: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> !bk_clash); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(iss_valid) |-> $past(iss_last)); // R7

endmodule

// File: tb/test_ilv_conflict_serializer.sv
`timescale 1ns/1ps
module test_ilv_conflict_serializer;

  localparam int NR = 4;
  localparam int AW = 16;
  localparam int NC = 4;
  localparam int NB = 2;
  localparam int CW = 2;
  localparam int BW = 1;
  localparam int KW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [NR-1:0] in_mask = '0;
  logic [NR*AW-1:0] in_addr = '0;
  logic          iss_valid;
  logic [NR-1:0] iss_vec;
  logic [NR*CW-1:0] iss_chan;
  logic [NR*BW-1:0] iss_bank;
  logic          iss_last;
  logic [KW-1:0] grp_cycles;

  always #2 clk = ~clk;

  ilv_conflict_serializer #(
    .N_REQ (NR), .ADDR_W (AW), .N_CHAN (NC), .N_BANK (NB)
  ) i_ilv_conflict_serializer (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
    .in_mask (in_mask), .in_addr (in_addr), .iss_valid (iss_valid),
    .iss_vec (iss_vec), .iss_chan (iss_chan), .iss_bank (iss_bank),
    .iss_last (iss_last), .grp_cycles (grp_cycles)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [NR-1:0] exp_vec [NR];
  int exp_n;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_ch(input logic [AW-1:0] a);
    logic [AW-1:0] s;
    s = a - 16'd1;
    return int'(s % 16'(NC));
  endfunction

  function automatic int ref_bk(input logic [AW-1:0] a);
    logic [AW-1:0] s;
    s = a - 16'd1;
    return int'(s % 16'(NB));
  endfunction

  task automatic model(input logic [NR*AW-1:0] addrs, input logic [NR-1:0] m);
    logic [NR-1:0] pend;
    logic [NR-1:0] g;
    pend  = m;
    exp_n = 0;
    while (pend != '0) begin
      g = '0;
      for (int i = 0; i < NR; i++) begin
        if (pend[i]) begin
          bit ok;
          ok = 1'b1;
          for (int j = 0; j < i; j++)
            if (g[j] && (ref_ch(addrs[j*AW +: AW]) == ref_ch(addrs[i*AW +: AW]) ||
                         ref_bk(addrs[j*AW +: AW]) == ref_bk(addrs[i*AW +: AW])))
              ok = 1'b0;
          if (ok) g[i] = 1'b1;
        end
      end
      exp_vec[exp_n] = g;
      pend = pend & ~g;
      exp_n++;
    end
  endtask

  task automatic run_group(input logic [NR*AW-1:0] addrs, input logic [NR-1:0] m,
                           input bit junk, input string tag);
    model(addrs, m);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_addr  = addrs;
    in_mask  = m;
    @(negedge clk);
    if (exp_n == 0) begin
      in_valid = 1'b0;
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        chk(iss_valid == 1'b0, {"R9 empty no issue ", tag}, int'(iss_valid), 0);
        chk(in_ready == 1'b1, {"R9 empty ready ", tag}, int'(in_ready), 1);
      end
      return;
    end
    if (junk) begin
      in_addr = {$urandom, $urandom};
      in_mask = NR'($urandom);
    end else begin
      in_valid = 1'b0;
    end
    chk(in_ready == 1'b0, {"R5 busy ready low ", tag}, int'(in_ready), 0);
    for (int c = 0; c < exp_n; c++) begin
      @(negedge clk);
      chk(iss_valid == 1'b1, {"R7 issue valid ", tag}, int'(iss_valid), 1);
      chk(iss_vec == exp_vec[c], {"R6 issue vector ", tag}, int'(iss_vec), int'(exp_vec[c]));
      chk(int'(grp_cycles) == c + 1, {"R8 cycle ordinal ", tag}, int'(grp_cycles), c + 1);
      chk(iss_last == (c == exp_n - 1), {"R8 last flag ", tag}, int'(iss_last), int'(c == exp_n - 1));
      for (int i = 0; i < NR; i++) begin
        if (iss_vec[i]) begin
          chk(int'(iss_chan[i*CW +: CW]) == ref_ch(addrs[i*AW +: AW]), {"R1 chan code ", tag},
              int'(iss_chan[i*CW +: CW]), ref_ch(addrs[i*AW +: AW]));
          chk(int'(iss_bank[i*BW +: BW]) == ref_bk(addrs[i*AW +: AW]), {"R2 bank code ", tag},
              int'(iss_bank[i*BW +: BW]), ref_bk(addrs[i*AW +: AW]));
          for (int j = i + 1; j < NR; j++)
            if (iss_vec[j]) begin
              chk(iss_chan[i*CW +: CW] != iss_chan[j*CW +: CW], {"R3 channel clash ", tag},
                  int'(iss_chan[j*CW +: CW]), -1);
              chk(iss_bank[i*BW +: BW] != iss_bank[j*BW +: BW], {"R4 bank clash ", tag},
                  int'(iss_bank[j*BW +: BW]), -1);
            end
        end
      end
      if (c == exp_n - 1) begin
        chk(in_ready == 1'b1, {"R8 ready on last ", tag}, int'(in_ready), 1);
        in_valid = 1'b0;
      end else begin
        chk(in_ready == 1'b0, {"R5 ready low mid ", tag}, int'(in_ready), 0);
      end
    end
    @(negedge clk);
    chk(iss_valid == 1'b0, {"R7 quiet after group ", tag}, int'(iss_valid), 0);
  endtask

  function automatic logic [NR*AW-1:0] pack4(input int a0, a1, a2, a3);
    return {16'(a3), 16'(a2), 16'(a1), 16'(a0)};
  endfunction

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R11 reset ready", int'(in_ready), 1);
    chk(iss_valid == 1'b0, "R11 reset valid", int'(iss_valid), 0);
    chk(iss_last == 1'b0, "R11 reset last", int'(iss_last), 0);
    chk(grp_cycles == '0, "R11 reset count", int'(grp_cycles), 0);

    // R10 stride of five: channels all distinct, banks limit to pairs
    run_group(pack4(1, 6, 11, 16), 4'hF, 1'b0, "R10 stride5");
    chk(exp_n == 2 && exp_vec[0] == 4'b0011 && exp_vec[1] == 4'b1100,
        "R10 stride5 schedule", exp_n, 2);
    // R10 stride of four: every lane on channel code 0 bank code 0
    run_group(pack4(1, 5, 9, 13), 4'hF, 1'b1, "R10 stride4");
    chk(exp_n == 4 && exp_vec[0] == 4'b0001 && exp_vec[3] == 4'b1000,
        "R10 stride4 schedule", exp_n, 4);
    run_group(pack4(1, 2, 3, 4), 4'hF, 1'b0, "R4 consecutive");
    run_group(pack4(7, 7, 7, 7), 4'hF, 1'b1, "R3 duplicates");
    run_group(pack4(9, 3, 2, 8), 4'b0100, 1'b0, "R9 single lane");
    run_group(pack4(1, 6, 11, 16), 4'b0000, 1'b0, "R9 all masked");
    run_group(pack4(1, 5, 2, 3), 4'b1110, 1'b1, "R6 lane0 off");
    run_group(pack4(0, 4, 8, 12), 4'hF, 1'b0, "R1 address zero");

    for (int n = 0; n < 300; n++) begin
      logic [NR*AW-1:0] a;
      for (int i = 0; i < NR; i++) a[i*AW +: AW] = 16'($urandom_range(1, 24));
      run_group(a, NR'($urandom), bit'($urandom_range(0, 1)), "R6 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule